// File: doc/BRIEF.md
# Programmable Phase Address Generator for a Table-Lookup Oscillator

This block produces the read address for an external waveform table, so that the table and the address together form a numerically controlled oscillator. A host programs a tuning word and a phase-offset word through a small register bus. On every clock, a phase accumulator advances by the tuning word and wraps at its own width. A second adder then adds the phase-offset word to the running phase. The top bits of that sum, held in a register, drive the table address.

A third register hands the external table to one of two owners, the host or the oscillator. While the host owns the table, for example to load samples, the accumulator stays at zero. The host then writes zero to the ownership bit to start the oscillator from phase zero plus the offset. Both tuning words can be rewritten while the oscillator runs. A new value takes effect on the next clock, with no restart. With a 32-bit accumulator and an 80 MHz clock, the frequency step is about 0.0186 Hz.

Top module: `nco_phase_gen`

## Requirements
- R1: Register select 0 holds the frequency word. A write (wr_en high, reg_sel 0) stores wr_data at the clock edge, and a later read returns the stored value unchanged.
- R2: Register select 1 holds the phase-offset word, with the same write and read behaviour as R1.
- R3: While the oscillator owns the table, the accumulator adds the frequency word at every clock edge, modulo 2^ACC_W.
- R4: At each clock edge, tbl_addr is loaded with the upper ADDR_W bits of (accumulator + phase word), using the values those two had before the edge. The sum wraps modulo 2^ACC_W.
- R5: Register select 2 is the ownership register, and only bit 0 of a write is stored. A read returns that bit in bit 0 and zeros above it. Bit value 1 gives the table to the host and 0 gives it to the oscillator. tbl_owner_host shows the stored bit.
- R6: While the host owns the table, the accumulator is held at zero, so tbl_addr shows only the upper bits of the phase word.
- R7: Register select 3 is reserved. Reading it returns zero, and writing it changes no register.
- R8: rd_data is registered. After a clock edge, it shows the value that the register selected by reg_sel held just before that edge.
- R9: A synchronous active-high reset clears both words, the accumulator, tbl_addr and rd_data, and sets the ownership bit to 1 (host).
- R10: Writes to the frequency or phase word while the oscillator runs take effect from the next edge on, and the accumulator is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 frequency, 1 phase, 2 ownership, 3 reserved |
| wr_data | input | ACC_W | Write data |
| rd_data | output | ACC_W | Registered read-back of the selected register |
| tbl_owner_host | output | 1 | 1 when the host owns the table, 0 when the oscillator does |
| tbl_addr | output | ADDR_W | Registered table address |

## Verification
The bench builds the block with its default widths: a 32-bit accumulator and a 16-bit address. With these widths, a tuning word of half the phase circle wraps the accumulator every second step. A tuning word just under the full circle steps the address backwards. A phase word of all ones plus one step carries exactly across the wrap to address zero. The vector table covers these cases. The directed tests cover live retuning, the ownership bit ignoring its upper bits, and the one-edge delay of read-back.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FREQ  = 2'd0,
    SEL_PHASE = 2'd1,
    SEL_OWNER = 2'd2,
    SEL_RSVD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/nco_regfile.sv
module nco_regfile
  import nco_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     freq_q,
  output logic [W-1:0]     phase_q,
  output logic             owner_q,
  output logic [W-1:0]     rd_q
);
  localparam logic [W-1:0] ZERO = '0;

  reg_sel_e       sel;
  logic [W-1:0]   rd_next;

  assign sel = reg_sel_e'(reg_sel);

  always_comb begin
    case (sel)
      SEL_FREQ:  rd_next = freq_q;
      SEL_PHASE: rd_next = phase_q;
      SEL_OWNER: rd_next = {ZERO[W-1:1], owner_q};
      default:   rd_next = ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q  <= ZERO;
      phase_q <= ZERO;
      owner_q <= 1'b1;
      rd_q    <= ZERO;
    end else begin
      rd_q <= rd_next;
      if (wr_en) begin
        case (sel)
          SEL_FREQ:  freq_q  <= wr_data;
          SEL_PHASE: phase_q <= wr_data;
          SEL_OWNER: owner_q <= wr_data[0];
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] step,
  output logic [W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst || hold) acc_q <= '0;
    else             acc_q <= acc_q + step;
  end
endmodule

// File: rtl/nco_addr.sv
module nco_addr #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  phase_acc,
  input  logic [ACC_W-1:0]  phase_ofs,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int TOP = ACC_W - 1;

  logic [ACC_W-1:0] sum;

  generate
    if (ADDR_W > ACC_W) begin : g_bad_width
      initial $display("nco_addr: ADDR_W must not exceed ACC_W");
    end
  endgenerate

  assign sum = phase_acc + phase_ofs;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= sum[TOP -: ADDR_W];
  end
endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [ACC_W-1:0]  wr_data,
  output logic [ACC_W-1:0]  rd_data,
  output logic              tbl_owner_host,
  output logic [ADDR_W-1:0] tbl_addr
);
  logic [ACC_W-1:0] freq_q;
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] acc_q;

  nco_regfile #(.W(ACC_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .reg_sel (reg_sel),
    .wr_data (wr_data),
    .freq_q  (freq_q),
    .phase_q (phase_q),
    .owner_q (tbl_owner_host),
    .rd_q    (rd_data)
  );

  nco_accum #(.W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .hold  (tbl_owner_host),
    .step  (freq_q),
    .acc_q (acc_q)
  );

  nco_addr #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .phase_acc (acc_q),
    .phase_ofs (phase_q),
    .addr_q    (tbl_addr)
  );
endmodule

// File: rtl/nco_phase_gen_chk.sv
module nco_phase_gen_chk #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        reg_sel,
  input logic [ACC_W-1:0]  wr_data,
  input logic              tbl_owner_host,
  input logic [ADDR_W-1:0] tbl_addr,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ACC_W-1:0]  freq_q,
  input logic [ACC_W-1:0]  phase_q
);
  logic [ACC_W-1:0] sum_w;
  assign sum_w = acc_q + phase_q;

  p_freq_wr_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd0) |=> freq_q == $past(wr_data));

  p_phase_wr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd1) |=> phase_q == $past(wr_data));

  p_acc_step_r3: assert property (@(posedge clk) disable iff (rst)
    !tbl_owner_host |=> acc_q == $past(acc_q) + $past(freq_q));

  p_addr_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tbl_addr == $past(sum_w[ACC_W-1 -: ADDR_W]));

  p_owner_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd2) |=> tbl_owner_host == $past(wr_data[0]));

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (rst)
    tbl_owner_host |=> acc_q == '0);

  p_rsvd_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd3) |=>
      ($stable(freq_q) && $stable(phase_q) && $stable(tbl_owner_host)));
endmodule

bind nco_phase_gen nco_phase_gen_chk #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/nco_phase_gen_test.sv
module nco_phase_gen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  reg_sel;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        tbl_owner_host;
  logic [15:0] tbl_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nco_phase_gen uut (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .reg_sel        (reg_sel),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .tbl_owner_host (tbl_owner_host),
    .tbl_addr       (tbl_addr)
  );

  // {freq word, phase word, edges after start}
  localparam logic [95:0] VEC [6] = '{
    {32'h0001_0000, 32'h0000_0000, 32'd5},
    {32'h8000_0000, 32'h0000_0000, 32'd4},
    {32'h0000_4000, 32'h1234_0000, 32'd9},
    {32'hFFFF_0000, 32'h0000_0000, 32'd3},
    {32'h0000_0001, 32'hFFFF_FFFF, 32'd2},
    {32'h0000_0000, 32'hABCD_1234, 32'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; reg_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    wr_en = 1'b0; reg_sel = sel;
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] model_addr(input logic [31:0] f, input logic [31:0] p, input int n);
    logic [31:0] t;
    t = 32'(n - 1) * f + p;
    return t[31:16];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; wr_en = 1'b0; reg_sel = 2'd0; wr_data = '0;
    step(3);
    rst = 1'b0;

    // R9 reset state
    check("R9 addr", {16'h0, tbl_addr}, 32'h0);
    check("R9 owner", {31'h0, tbl_owner_host}, 32'h1);
    rd(2'd0, v); check("R9 freq", v, 32'h0);
    rd(2'd1, v); check("R9 phase", v, 32'h0);
    rd(2'd2, v); check("R9 owner reg", v, 32'h1);

    // R1 / R2 read-back
    wr(2'd0, 32'hDEAD_BEEF); rd(2'd0, v); check("R1 freq readback", v, 32'hDEAD_BEEF);
    wr(2'd1, 32'h1357_9BDF); rd(2'd1, v); check("R2 phase readback", v, 32'h1357_9BDF);

    // R7 reserved register
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R7 rsvd reads zero", v, 32'h0);
    rd(2'd0, v); check("R7 freq untouched", v, 32'hDEAD_BEEF);
    rd(2'd1, v); check("R7 phase untouched", v, 32'h1357_9BDF);
    rd(2'd2, v); check("R7 owner untouched", v, 32'h1);

    // R5 only bit 0 stored
    wr(2'd2, 32'hFFFF_FFFE);
    check("R5 owner to osc", {31'h0, tbl_owner_host}, 32'h0);
    rd(2'd2, v); check("R5 owner readback", v, 32'h0);
    wr(2'd2, 32'h0000_0003);
    check("R5 owner to host", {31'h0, tbl_owner_host}, 32'h1);
    rd(2'd2, v); check("R5 owner readback 1", v, 32'h1);

    // R6 host owns: accumulator held, address shows phase only
    wr(2'd0, 32'h0001_0000);
    wr(2'd1, 32'h0555_0000);
    step(4);
    check("R6 hold at zero", {16'h0, tbl_addr}, 32'h0555);

    // R8 read data is registered (old value on the write edge)
    wr_en = 1'b1; reg_sel = 2'd0; wr_data = 32'h1111_2222;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 read shows pre-edge value", rd_data, 32'h0001_0000);
    rd(2'd0, v); check("R8 read new value", v, 32'h1111_2222);

    // R3 / R4 vector table
    foreach (VEC[i]) begin
      logic [31:0] f, p;
      int n;
      f = VEC[i][95:64]; p = VEC[i][63:32]; n = int'(VEC[i][31:0]);
      wr(2'd2, 32'h1);
      wr(2'd0, f);
      wr(2'd1, p);
      wr(2'd2, 32'h0);
      step(n);
      check($sformatf("R3 R4 vector %0d", i), {16'h0, tbl_addr}, {16'h0, model_addr(f, p, n)});
    end

    // R10 live retune of frequency then phase
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0010_0000);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    step(3);
    wr(2'd0, 32'h0100_0000);
    step(2);
    check("R10 live freq", {16'h0, tbl_addr}, 32'h0140);
    wr(2'd1, 32'h2000_0000);
    check("R10 phase edge uses old", {16'h0, tbl_addr}, 32'h0240);
    step(1);
    check("R10 live phase", {16'h0, tbl_addr}, 32'h2340);

    finish_run();
  end
endmodule